// File: doc/BRIEF.md
# Input Transition Sequence Detector

This block samples a one-bit serial input on every rising clock edge and reports when the two most recent samples differ, i.e. when the input has changed value between consecutive samples (the pairs 01 and 10). It is meant for a designer who wants to compare the two classic output styles of a state machine. Both styles see the same input, so their timing can be compared directly.

Two independent state machines perform the same detection side by side. The first is a five-state machine whose flag is decoded only from its state register, so the flag moves only at clock edges. The second is a three-state machine whose flag combines its state with the live input, so it reacts within the cycle. A synchronous active-high reset clears both machines to a state with no history.

Top module: `edge_pair_detector`

## Requirements
- R1: While `rst` is high, `moore_flag` and `mealy_flag` are both 0 whatever `din` does, and a synchronous reset leaves both machines with no sample history.
- R2: `moore_flag` is 1 in the cycle after a rising edge at which the sampled `din` differs from the value sampled at the previous edge. It is 0 otherwise, including after the first sample following reset.
- R3: Once at least one sample has been taken since reset, `mealy_flag` is 1 exactly when the live `din` differs from the most recently sampled value. With no sample since reset it is 0.
- R4: `mealy_flag` follows a change of `din` within the same clock cycle, without waiting for a clock edge.
- R5: Outside reset, `moore_flag` in each cycle equals the value `mealy_flag` had in the previous cycle, so the state-only flag lags by exactly one cycle.
- R6: A change of `din` between clock edges has no effect on `moore_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| moore_flag | output | 1 | Transition flag decoded from state only |
| mealy_flag | output | 1 | Transition flag from state and live input |

## Verification
Within one clock period, the combinational flag must respond to a toggle of `din` while the registered flag must not move. The bench provokes this by flipping `din` in the middle of each cycle of every six-bit input sequence. It then reads both flags before the next edge. The flip must change `mealy_flag` and must leave `moore_flag` at the value it had after the edge. The bench also judges, at each edge, whether the new `moore_flag` equals the `mealy_flag` held just before that edge.

// File: rtl/edge_pair_detector.sv
module edge_pair_detector (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic moore_flag,
  output logic mealy_flag
);

  typedef enum logic [2:0] {
    MO_IDLE = 3'd0,
    MO_LOW  = 3'd1,
    MO_HIGH = 3'd2,
    MO_ROSE = 3'd3,
    MO_FELL = 3'd4
  } moore_t;

  typedef enum logic [1:0] {
    ME_IDLE = 2'd0,
    ME_LOW  = 2'd1,
    ME_HIGH = 2'd2
  } mealy_t;

  moore_t mo_q, mo_d;
  mealy_t me_q, me_d;
  logic   me_out;

  always_comb begin
    case (mo_q)
      MO_IDLE: mo_d = din ? MO_HIGH : MO_LOW;
      MO_LOW:  mo_d = din ? MO_ROSE : MO_LOW;
      MO_HIGH: mo_d = din ? MO_HIGH : MO_FELL;
      MO_ROSE: mo_d = din ? MO_HIGH : MO_FELL;
      MO_FELL: mo_d = din ? MO_ROSE : MO_LOW;
      default: mo_d = MO_IDLE;
    endcase
  end

  always_comb begin
    me_out = 1'b0;
    case (me_q)
      ME_IDLE: me_d = din ? ME_HIGH : ME_LOW;
      ME_LOW: begin
        me_d   = din ? ME_HIGH : ME_LOW;
        me_out = din;
      end
      ME_HIGH: begin
        me_d   = din ? ME_HIGH : ME_LOW;
        me_out = ~din;
      end
      default: me_d = ME_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mo_q <= MO_IDLE;
      me_q <= ME_IDLE;
    end else begin
      mo_q <= mo_d;
      me_q <= me_d;
    end
  end

  assign moore_flag = ~rst & ((mo_q == MO_ROSE) | (mo_q == MO_FELL));
  assign mealy_flag = ~rst & me_out;

endmodule

// File: rtl/edge_pair_detector_checker.sv
module edge_pair_detector_checker (
  input logic clk,
  input logic rst,
  input logic din,
  input logic moore_flag,
  input logic mealy_flag
);

  logic [1:0] seen;
  logic       h1, h2;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 2'd0;
      h1   <= 1'b0;
      h2   <= 1'b0;
    end else begin
      if (seen != 2'd2) seen <= seen + 2'd1;
      h2 <= h1;
      h1 <= din;
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!moore_flag && !mealy_flag));

  a_r2_moore_on_change: assert property (@(posedge clk) disable iff (rst)
    moore_flag == (seen == 2'd2 && h1 != h2));

  a_r3_mealy_live_compare: assert property (@(posedge clk) disable iff (rst)
    mealy_flag == (seen != 2'd0 && din != h1));

  a_r5_moore_lags_mealy: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (moore_flag == $past(mealy_flag)));

endmodule

bind edge_pair_detector edge_pair_detector_checker chk (
  .clk(clk), .rst(rst), .din(din),
  .moore_flag(moore_flag), .mealy_flag(mealy_flag)
);

// File: tb/edge_pair_detector_test.sv
`timescale 1ns/1ps
module edge_pair_detector_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic moore_flag, mealy_flag;
  int   errors = 0;
  int   checks = 0;

  always #2.5 clk = ~clk;

  edge_pair_detector uut (
    .clk(clk), .rst(rst), .din(din),
    .moore_flag(moore_flag), .mealy_flag(mealy_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int seq = 0; seq < 64; seq++) begin
      int   count;
      logic last;
      logic mealy_before;
      logic moore_now;
      logic bit_v;
      rst = 1'b1;
      for (int k = 0; k < 2; k++) begin
        @(posedge clk); #1;
        din = k[0];
        #0.5;
        check("R1 moore in reset", moore_flag, 1'b0);
        check("R1 mealy in reset", mealy_flag, 1'b0);
      end
      rst = 1'b0;
      count = 0;
      last = 1'b0;
      for (int i = 0; i < 6; i++) begin
        bit_v = seq[i];
        din = bit_v;
        #0.5;
        check("R3 mealy compare", mealy_flag, (count > 0) && (bit_v != last));
        moore_now = moore_flag;
        din = ~bit_v;
        #0.5;
        check("R4 mealy follows din", mealy_flag, (count > 0) && (~bit_v != last));
        check("R6 moore ignores din", moore_flag, moore_now);
        din = bit_v;
        #0.5;
        mealy_before = mealy_flag;
        @(posedge clk); #1;
        check("R2 moore after edge", moore_flag, (count > 0) && (bit_v != last));
        check("R5 moore lags mealy", moore_flag, mealy_before);
        count++;
        last = bit_v;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule